// File: doc/BRIEF.md
# Register-Indirect Store with Terminal Port

This block is the execute-stage slice that carries out a move from a register into the memory location that another register points at. It takes the value of the source register, the value of the address register and the addressing mode of the source operand. From these it issues one full-word write to a byte-addressed data memory through a simple synchronous write port. Every result is registered, so it appears on the outputs one clock after the command is sampled.

One address is reserved as an output terminal. A store whose unmasked address register value equals that location also sends the stored word to a terminal data port, with a valid strobe that lasts one cycle. The memory write still takes place. The memory address uses only the low 24 bits of the address register. The terminal decode compares all 32 bits, so an address that differs only in its upper byte reaches memory but never the terminal.

A register-indirect destination is allowed only when the source operand is a whole direct register. Any other source mode produces a one-cycle error pulse, and that command makes no write of any kind.

Top module: `indirect_store_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `mem_we`, `mem_be`, `term_valid` and `err` are low, and `mem_addr`, `mem_wdata` and `term_data` are zero.
- R2: A command with `cmd_valid`=1 and `src_mode`=0 (whole direct register) drives `mem_we`=1 one cycle later. In that cycle `mem_addr` equals bits 23:0 of `addr_value`, `mem_wdata` equals `src_value`, and `mem_be` is 4'b1111.
- R3: `mem_we`, `term_valid` and `err` each stay high for exactly one cycle per command. In a cycle that follows an idle input cycle, all three are low and `mem_be` is 4'b0000.
- R4: A legal store whose full 32-bit `addr_value` equals 32'h00FFFFFC also drives `term_valid`=1 and `term_data`=`src_value`, in the same cycle as its memory write.
- R5: A legal store whose `addr_value` has bits 23:0 equal to 24'hFFFFFC but nonzero upper bits writes memory at 24'hFFFFFC and leaves `term_valid` low.
- R6: A command with `src_mode` of 1 (low half), 2 (high half) or 3 (indirect) drives `err`=1 one cycle later, with `mem_we` and `term_valid` low in that cycle.
- R7: When `cmd_valid` is low, the next cycle shows no write, no terminal strobe and no error, whatever the other inputs carry.
- R8: `term_data` keeps the last word sent to the terminal until the next terminal store, including across non-terminal stores and errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A store command is present this cycle |
| src_mode | input | 2 | Source operand mode: 0 whole register, 1 low half, 2 high half, 3 indirect |
| src_value | input | 32 | Value read from the source register |
| addr_value | input | 32 | Value read from the address register |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 24 | Byte address of the write |
| mem_wdata | output | 32 | Word to write |
| mem_be | output | 4 | Byte enables, all set during a write |
| term_valid | output | 1 | Terminal word strobe |
| term_data | output | 32 | Last word sent to the terminal |
| err | output | 1 | Illegal source mode strobe |

## Verification
Each output is a single register stage away from the command inputs, so every result of a command appears exactly one cycle after the edge that samples it. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, halfway through the cycle in which the results are valid. It checks the pulse width by issuing an idle cycle after a store and reading the strobes again one cycle later. It checks that `term_data` is held by reading it after later non-terminal commands.

// File: rtl/indirect_store_unit.sv
module indirect_store_unit #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 24,
  parameter int MODE_W    = 2,
  parameter logic [DATA_W-1:0] TERM_ADDR = 32'h00FF_FFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [MODE_W-1:0] src_mode,
  input  logic [DATA_W-1:0] src_value,
  input  logic [DATA_W-1:0] addr_value,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W/8-1:0] mem_be,
  output logic              term_valid,
  output logic [DATA_W-1:0] term_data,
  output logic              err
);
  localparam int BE_W = DATA_W / 8;
  localparam logic [MODE_W-1:0] MODE_DIRECT = '0;

  logic legal, hits_term;

  assign legal     = cmd_valid && (src_mode == MODE_DIRECT);
  assign hits_term = (addr_value == TERM_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_be     <= '0;
      term_valid <= 1'b0;
      term_data  <= '0;
      err        <= 1'b0;
    end else begin
      mem_we     <= legal;
      mem_be     <= {BE_W{legal}};
      term_valid <= legal && hits_term;
      err        <= cmd_valid && !legal;
      if (legal) begin
        mem_addr  <= addr_value[ADDR_W-1:0];
        mem_wdata <= src_value;
      end
      if (legal && hits_term)
        term_data <= src_value;
    end
  end
endmodule

module indirect_store_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int MODE_W = 2,
  parameter logic [DATA_W-1:0] TERM_ADDR = 32'h00FF_FFFC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [MODE_W-1:0] src_mode,
  input logic [DATA_W-1:0] src_value,
  input logic [DATA_W-1:0] addr_value,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W/8-1:0] mem_be,
  input logic              term_valid,
  input logic [DATA_W-1:0] term_data,
  input logic              err
);
  // R2
  store_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && src_mode == '0) |=> (mem_we && mem_be == '1 &&
      mem_addr == $past(addr_value[ADDR_W-1:0]) && mem_wdata == $past(src_value)));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, err}));

  // R4
  term_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid |-> (mem_we && term_data == mem_wdata));

  // R5
  alias_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && addr_value != TERM_ADDR) |=> !term_valid);

  // R6
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && src_mode != '0) |=> (err && !mem_we && !term_valid));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!mem_we && !term_valid && !err));

  // R8
  term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !term_valid && $past(rst_n)) |-> $stable(term_data));
endmodule

bind indirect_store_unit indirect_store_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_W(MODE_W), .TERM_ADDR(TERM_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .src_mode(src_mode),
  .src_value(src_value), .addr_value(addr_value), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
  .term_valid(term_valid), .term_data(term_data), .err(err)
);

// File: tb/tb_indirect_store_unit.sv
module tb_indirect_store_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {valid, mode[1:0], src[31:0], addr[31:0], exp_we, exp_term, exp_err}
  localparam logic [69:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 32'hDEAD_BEEF, 32'h0000_1000, 3'b100},  // R2
    {1'b1, 2'd0, 32'h0000_0068, 32'h00FF_FFFC, 3'b110},  // R4
    {1'b1, 2'd0, 32'h1234_5678, 32'h01FF_FFFC, 3'b100},  // R5
    {1'b1, 2'd1, 32'hAAAA_5555, 32'h0000_0010, 3'b001},  // R6
    {1'b1, 2'd3, 32'h0BAD_0BAD, 32'h00FF_FFFC, 3'b001},  // R6
    {1'b0, 2'd0, 32'hCAFE_F00D, 32'h00FF_FFFC, 3'b000},  // R7
    {1'b1, 2'd0, 32'hFFFF_FFFF, 32'hFF00_0004, 3'b100},  // R2
    {1'b1, 2'd2, 32'h5555_AAAA, 32'h00FF_FFFC, 3'b001}   // R6
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] src_mode = '0;
  logic [31:0] src_value = '0, addr_value = '0;
  logic mem_we, term_valid, err;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata, term_data;
  logic [3:0] mem_be;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  indirect_store_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .src_mode(src_mode),
    .src_value(src_value), .addr_value(addr_value), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .term_valid(term_valid), .term_data(term_data), .err(err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [1:0] m, input logic [31:0] s, input logic [31:0] a);
    cmd_valid = v; src_mode = m; src_value = s; addr_value = a;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] last_term;
    @(negedge clk); @(negedge clk);
    chk("R1", "mem_we in reset", {31'd0, mem_we}, 32'd0);
    chk("R1", "term_valid in reset", {31'd0, term_valid}, 32'd0);
    chk("R1", "err in reset", {31'd0, err}, 32'd0);
    chk("R1", "term_data in reset", term_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "mem_addr after reset", {8'd0, mem_addr}, 32'd0);
    chk("R1", "mem_be after reset", {28'd0, mem_be}, 32'd0);

    last_term = 32'd0;
    for (int i = 0; i < NVEC; i++) begin
      logic [69:0] v;
      v = VEC[i];
      apply(v[69], v[68:67], v[66:35], v[34:3]);
      chk("R2", "mem_we", {31'd0, mem_we}, {31'd0, v[2]});
      chk("R4", "term_valid", {31'd0, term_valid}, {31'd0, v[1]});
      chk("R6", "err", {31'd0, err}, {31'd0, v[0]});
      chk("R2", "mem_be", {28'd0, mem_be}, v[2] ? 32'hF : 32'h0);
      if (v[2]) begin
        chk("R2", "mem_addr", {8'd0, mem_addr}, {8'd0, v[26:3]});
        chk("R2", "mem_wdata", mem_wdata, v[66:35]);
      end
      if (v[1]) last_term = v[66:35];
      chk("R8", "term_data", term_data, last_term);
    end

    // R3: strobes last one cycle
    apply(1'b1, 2'd0, 32'h0000_0021, 32'h00FF_FFFC);
    chk("R4", "term_valid", {31'd0, term_valid}, 32'd1);
    chk("R4", "term_data", term_data, 32'h0000_0021);
    apply(1'b0, 2'd0, 32'h0, 32'h0);
    chk("R3", "mem_we after idle", {31'd0, mem_we}, 32'd0);
    chk("R3", "term_valid after idle", {31'd0, term_valid}, 32'd0);
    chk("R3", "mem_be after idle", {28'd0, mem_be}, 32'd0);
    apply(1'b1, 2'd1, 32'h0, 32'h0);
    apply(1'b0, 2'd0, 32'h0, 32'h0);
    chk("R3", "err after idle", {31'd0, err}, 32'd0);

    // R5: alias at top byte, term_data held
    apply(1'b1, 2'd0, 32'h7777_7777, 32'h80FF_FFFC);
    chk("R5", "alias mem_we", {31'd0, mem_we}, 32'd1);
    chk("R5", "alias mem_addr", {8'd0, mem_addr}, 32'h00FF_FFFC);
    chk("R5", "alias term_valid", {31'd0, term_valid}, 32'd0);
    chk("R8", "alias term_data held", term_data, 32'h0000_0021);

    // back-to-back terminal stores
    apply(1'b1, 2'd0, 32'h0000_0041, 32'h00FF_FFFC);
    chk("R4", "b2b first", term_data, 32'h0000_0041);
    apply(1'b1, 2'd0, 32'h0000_0042, 32'h00FF_FFFC);
    chk("R4", "b2b second valid", {31'd0, term_valid}, 32'd1);
    chk("R4", "b2b second data", term_data, 32'h0000_0042);

    // R1: reset while a store is pending
    cmd_valid = 1'b1; src_mode = 2'd0; src_value = 32'h1111_1111; addr_value = 32'h00FF_FFFC;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "mem_we under reset", {31'd0, mem_we}, 32'd0);
    chk("R1", "term_data under reset", term_data, 32'd0);
    cmd_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "term_valid after reset", {31'd0, term_valid}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule